// File: doc/BRIEF.md
# Processor Presence and Hot-Plug Event Registers

This block keeps a flat bitmap of which processors are present. Each processor has one bit, indexed by its numeric ID. Software reads the bitmap one byte at a time through a small I/O window. A hot-plug event port adds or removes one processor. Every accepted event also latches a dedicated bit in the general-purpose event status byte. That bit is combined with the device hot-plug bit and the other power-management interrupt sources to form a level system control interrupt.

Firmware handles the interrupt in three steps. It reads the window to learn the new processor set. It then clears the status bit by writing a one to it. The interrupt drops on the next cycle, unless another event arrived in the meantime. At reset the bitmap is loaded from a mask of the processors present at start-up. An event naming an ID outside the bitmap changes no state and raises a one-cycle error flag.

Top module: `cpu_presence_regs`

## Requirements
- R1: After reset the bitmap equals `boot_mask`, `gpe_sts` is 0x00, `hp_err` is low, and `sci` is low while `pm_irq_in` is low.
- R2: A read with `io_rd` high at address 0xAF00+k (k from 0 to 31) returns bitmap byte k in the same cycle, with `io_rdata_en` high. Processor n is bit n mod 8 of byte n/8.
- R3: A plug event (`hp_valid` high, `hp_remove` low, `hp_id` below 256) sets bit `hp_id` of the bitmap, visible from the next cycle.
- R4: An unplug event (`hp_remove` high) clears bit `hp_id` of the bitmap, visible from the next cycle.
- R5: Every event with an ID below 256, plug or unplug, sets `gpe_sts` bit 2 (0x04) on the next cycle.
- R6: An event whose 9-bit `hp_id` is 256 or more changes neither the bitmap nor `gpe_sts`, and drives `hp_err` high for exactly the next cycle.
- R7: `sci` is high exactly when `gpe_sts & gpe_en` has bit 1 or bit 2 set, or `pm_irq_in` is high. The other status bits never raise it.
- R8: A cycle with `sts_clr_wr` high clears each `gpe_sts` bit whose `sts_clr_data` bit is 1, from the next cycle. Bits written 0 keep their value.
- R9: If an event sets bit 2 in the same cycle that a clear targets bit 2, bit 2 ends set.
- R10: Writes (`io_wr`) into the window leave the bitmap unchanged.
- R11: A read outside 0xAF00 to 0xAF1F gives `io_rdata_en` low and `io_rdata` 0x00.
- R12: A `dev_evt` pulse sets `gpe_sts` bit 1 (0x02) on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_mask | input | 256 | Processors present at start-up, loaded at reset |
| hp_valid | input | 1 | Hot-plug event strobe |
| hp_remove | input | 1 | 0 = plug, 1 = unplug |
| hp_id | input | 9 | Processor ID of the event |
| hp_err | output | 1 | One-cycle flag for an out-of-range ID |
| io_addr | input | 16 | I/O byte address |
| io_rd | input | 1 | Byte read strobe |
| io_wr | input | 1 | Byte write strobe |
| io_wdata | input | 8 | Write data, discarded |
| io_rdata | output | 8 | Read data |
| io_rdata_en | output | 1 | High when the block drives read data |
| dev_evt | input | 1 | Device hot-plug event strobe |
| sts_clr_wr | input | 1 | Status clear strobe |
| sts_clr_data | input | 8 | Write-one-to-clear mask for the status byte |
| gpe_en | input | 8 | Event enable byte |
| pm_irq_in | input | 1 | Other power-management interrupt sources |
| gpe_sts | output | 8 | Event status byte |
| sci | output | 1 | Level system control interrupt |

## Verification
Each kind of internal fault shows up at a different point. A corrupted or wrongly indexed bitmap bit shows up on the next read of the byte that holds it, one cycle after the event. A status latch that misses a set, or lets a clear win, shows at `gpe_sts` and on `sci` one cycle after the event. Reads are combinational, so a decode fault appears in the same cycle as the access. The bench tracks its own model of the bitmap and compares every byte of the window after the corner cases.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;
   typedef enum logic {HP_PLUG = 1'b0, HP_UNPLUG = 1'b1} hp_kind_e;
endpackage

// File: rtl/presence_bitmap.sv
module presence_bitmap
   import cpuhp_pkg::*;
#(
   parameter int ID_W = 8,
   parameter int ADDR_W = 16,
   parameter logic [15:0] BASE_ADDR = 16'hAF00
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [(1<<ID_W)-1:0]  boot_mask,
   input  logic                  hp_valid,
   input  logic                  hp_remove,
   input  logic [ID_W:0]         hp_id,
   input  logic [ADDR_W-1:0]     io_addr,
   input  logic                  io_rd,
   input  logic                  io_wr,
   input  byte_t                 io_wdata,
   output byte_t                 io_rdata,
   output logic                  io_rdata_en,
   output logic                  hp_err,
   output logic                  evt_ok
);
   localparam int NUM_IDS = 1 << ID_W;
   localparam int BYTES   = NUM_IDS / BYTE_W;
   localparam int OFF_W   = $clog2(BYTES);

   generate
      if (ID_W < 4) begin : g_bad_id_w
         $error("ID_W must be at least 4");
      end
      if (ADDR_W < OFF_W + 1) begin : g_bad_addr_w
         $error("ADDR_W too small for the window");
      end
   endgenerate

   logic [NUM_IDS-1:0] map_q;
   logic               err_q;
   logic               id_ok;
   hp_kind_e           kind;
   logic [ADDR_W-1:0]  off;
   logic               in_win;
   logic [OFF_W-1:0]   sel;

   assign id_ok  = ~hp_id[ID_W];
   assign evt_ok = hp_valid & id_ok;
   assign kind   = hp_kind_e'(hp_remove);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         map_q <= boot_mask;
         err_q <= 1'b0;
      end else begin
         err_q <= hp_valid & ~id_ok;
         if (evt_ok)
            map_q[hp_id[ID_W-1:0]] <= (kind == HP_PLUG);
      end
   end

   assign hp_err = err_q;

   // window decode: the offset wraps below the base, so one compare suffices
   assign off         = io_addr - ADDR_W'(BASE_ADDR);
   assign in_win      = off < ADDR_W'(BYTES);
   assign sel         = off[OFF_W-1:0];
   assign io_rdata_en = io_rd & in_win;
   assign io_rdata    = io_rdata_en ? map_q[{sel, 3'b000} +: BYTE_W] : '0;

   // R3: a plug leaves the named bit set
   a_r3_plug_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_ok && !hp_remove) |=> map_q[$past(hp_id[ID_W-1:0])]);
   // R4: an unplug leaves the named bit clear
   a_r4_unplug_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_ok && hp_remove) |=> !map_q[$past(hp_id[ID_W-1:0])]);
   // R6: out-of-range ID flags an error and leaves the bitmap alone
   a_r6_bad_id: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_valid && hp_id[ID_W]) |=> (hp_err && $stable(map_q)));
   // R10: window writes do not reach the bitmap
   a_r10_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_wdata != '0 && !evt_ok) |=> $stable(map_q));
endmodule

// File: rtl/gpe_status.sv
module gpe_status
   import cpuhp_pkg::*;
#(
   parameter int GPE_W = 8,
   parameter int CPU_BIT = 2,
   parameter int DEV_BIT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_set,
   input  logic             dev_set,
   input  logic             clr_wr,
   input  logic [GPE_W-1:0] clr_data,
   output logic [GPE_W-1:0] sts_q
);
   generate
      for (genvar b = 0; b < GPE_W; b++) begin : g_bit
         logic set_b, clr_b;
         if (b == CPU_BIT) begin : g_cpu
            assign set_b = cpu_set;
         end else if (b == DEV_BIT) begin : g_dev
            assign set_b = dev_set;
         end else begin : g_none
            assign set_b = 1'b0;
         end
         assign clr_b = clr_wr & clr_data[b];
         // a set in the same cycle as a clear keeps the bit
         always_ff @(posedge clk) begin
            if (!rst_n)     sts_q[b] <= 1'b0;
            else if (set_b) sts_q[b] <= 1'b1;
            else if (clr_b) sts_q[b] <= 1'b0;
         end
      end
   endgenerate

   // R9: processor event wins over a same-cycle clear
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_set |=> sts_q[CPU_BIT]);
   // R8: a clear without a competing set drops the bit
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_data[CPU_BIT] && !cpu_set) |=> !sts_q[CPU_BIT]);
   // R12: device event latches its bit
   a_r12_dev_sets: assert property (@(posedge clk) disable iff (!rst_n)
      dev_set |=> sts_q[DEV_BIT]);
endmodule

// File: rtl/sci_combine.sv
module sci_combine #(
   parameter int GPE_W = 8,
   parameter logic [7:0] SRC_MASK = 8'h06
) (
   input  logic [GPE_W-1:0] sts,
   input  logic [GPE_W-1:0] en,
   input  logic             pm_irq_in,
   output logic             sci
);
   logic [GPE_W-1:0] live;
   assign live = sts & en & GPE_W'(SRC_MASK);
   assign sci  = (|live) | pm_irq_in;
endmodule

// File: rtl/cpu_presence_regs.sv
module cpu_presence_regs
   import cpuhp_pkg::*;
#(
   parameter int ID_W = 8,
   parameter int ADDR_W = 16,
   parameter logic [15:0] BASE_ADDR = 16'hAF00,
   parameter int GPE_W = 8,
   parameter int CPU_BIT = 2,
   parameter int DEV_BIT = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [(1<<ID_W)-1:0]  boot_mask,
   input  logic                  hp_valid,
   input  logic                  hp_remove,
   input  logic [ID_W:0]         hp_id,
   output logic                  hp_err,
   input  logic [ADDR_W-1:0]     io_addr,
   input  logic                  io_rd,
   input  logic                  io_wr,
   input  logic [7:0]            io_wdata,
   output logic [7:0]            io_rdata,
   output logic                  io_rdata_en,
   input  logic                  dev_evt,
   input  logic                  sts_clr_wr,
   input  logic [GPE_W-1:0]      sts_clr_data,
   input  logic [GPE_W-1:0]      gpe_en,
   input  logic                  pm_irq_in,
   output logic [GPE_W-1:0]      gpe_sts,
   output logic                  sci
);
   localparam logic [7:0] SRC_MASK = 8'((1 << CPU_BIT) | (1 << DEV_BIT));

   generate
      if (CPU_BIT >= GPE_W || DEV_BIT >= GPE_W || GPE_W > 8) begin : g_bad_bits
         $error("status bit positions out of range");
      end
      if (CPU_BIT == DEV_BIT) begin : g_same_bit
         $error("processor and device status bits must differ");
      end
   endgenerate

   logic evt_ok;

   presence_bitmap #(.ID_W(ID_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_map (
      .clk(clk), .rst_n(rst_n), .boot_mask(boot_mask),
      .hp_valid(hp_valid), .hp_remove(hp_remove), .hp_id(hp_id),
      .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .io_rdata_en(io_rdata_en),
      .hp_err(hp_err), .evt_ok(evt_ok)
   );

   gpe_status #(.GPE_W(GPE_W), .CPU_BIT(CPU_BIT), .DEV_BIT(DEV_BIT)) u_sts (
      .clk(clk), .rst_n(rst_n), .cpu_set(evt_ok), .dev_set(dev_evt),
      .clr_wr(sts_clr_wr), .clr_data(sts_clr_data), .sts_q(gpe_sts)
   );

   sci_combine #(.GPE_W(GPE_W), .SRC_MASK(SRC_MASK)) u_sci (
      .sts(gpe_sts), .en(gpe_en), .pm_irq_in(pm_irq_in), .sci(sci)
   );

   // R5: every in-range event, either kind, flags the processor status bit
   a_r5_event_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_valid && !hp_id[ID_W]) |=> gpe_sts[CPU_BIT]);
   // R6: a bad ID never sets the processor status bit on its own
   a_r6_no_status: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_valid && hp_id[ID_W] && !gpe_sts[CPU_BIT]) |=> !gpe_sts[CPU_BIT]);
endmodule

// File: tb/cpu_presence_regs_test.sv
module cpu_presence_regs_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [255:0] boot_mask;
   logic         hp_valid = 1'b0, hp_remove = 1'b0;
   logic [8:0]   hp_id = '0;
   logic         hp_err;
   logic [15:0]  io_addr = '0;
   logic         io_rd = 1'b0, io_wr = 1'b0;
   logic [7:0]   io_wdata = '0;
   logic [7:0]   io_rdata;
   logic         io_rdata_en;
   logic         dev_evt = 1'b0, sts_clr_wr = 1'b0;
   logic [7:0]   sts_clr_data = '0, gpe_en = '0;
   logic         pm_irq_in = 1'b0;
   logic [7:0]   gpe_sts;
   logic         sci;

   int total = 0, bad = 0;
   logic [255:0] ref_map;
   logic [7:0]   ref_sts;

   always #2 clk = ~clk;

   cpu_presence_regs uut (
      .clk(clk), .rst_n(rst_n), .boot_mask(boot_mask),
      .hp_valid(hp_valid), .hp_remove(hp_remove), .hp_id(hp_id), .hp_err(hp_err),
      .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .io_rdata_en(io_rdata_en),
      .dev_evt(dev_evt), .sts_clr_wr(sts_clr_wr), .sts_clr_data(sts_clr_data),
      .gpe_en(gpe_en), .pm_irq_in(pm_irq_in), .gpe_sts(gpe_sts), .sci(sci)
   );

   // {remove, id}
   localparam logic [9:0] VEC [8] = '{
      {1'b0, 9'd10}, {1'b0, 9'd9}, {1'b1, 9'd0}, {1'b1, 9'd255},
      {1'b0, 9'd128}, {1'b1, 9'd3}, {1'b0, 9'd31}, {1'b1, 9'd10}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic en);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1;
      d = io_rdata; en = io_rdata_en;
      io_rd = 1'b0;
   endtask

   task automatic evt(input logic [8:0] id, input logic rem, output logic err);
      @(negedge clk);
      hp_valid = 1'b1; hp_id = id; hp_remove = rem;
      @(negedge clk);
      hp_valid = 1'b0;
      err = hp_err;
      if (id < 9'd256) begin
         ref_map[id[7:0]] = ~rem;
         ref_sts[2] = 1'b1;
      end
   endtask

   task automatic clr(input logic [7:0] m);
      @(negedge clk);
      sts_clr_wr = 1'b1; sts_clr_data = m;
      @(negedge clk);
      sts_clr_wr = 1'b0;
      ref_sts = ref_sts & ~m;
   endtask

   task automatic scan_all(input string req);
      logic [7:0] d; logic en; int miss;
      miss = 0;
      for (int k = 0; k < 32; k++) begin
         rd(16'hAF00 + 16'(k), d, en);
         if (d !== ref_map[k*8 +: 8] || en !== 1'b1) miss++;
      end
      chk(req, miss, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] d; logic en, err;
      boot_mask = '0;
      boot_mask[3:0] = 4'hF;
      boot_mask[255] = 1'b1;
      boot_mask[77] = 1'b1;
      ref_map = boot_mask;
      ref_sts = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 sts", gpe_sts, 8'h00);
      chk("R1 sci", sci, 1'b0);
      chk("R1 err", hp_err, 1'b0);
      scan_all("R1 R2 boot bitmap");
      rd(16'hAF09, d, en);
      chk("R2 byte9 id77", d, 8'h20);

      // vector table: events, readback, status, clear
      for (int i = 0; i < 8; i++) begin
         logic [8:0] id; logic rm;
         {rm, id} = VEC[i];
         evt(id, rm, err);
         chk(rm ? "R4 no err" : "R3 no err", err, 1'b0);
         rd(16'hAF00 + 16'(id[7:3]), d, en);
         chk(rm ? "R4 byte" : "R3 byte", d, ref_map[id[7:3]*8 +: 8]);
         chk("R5 sts", gpe_sts, ref_sts);
         clr(8'h04);
         chk("R8 cleared", gpe_sts, ref_sts);
      end
      scan_all("R3 R4 full scan");

      // R6 out-of-range IDs
      evt(9'd300, 1'b0, err);
      chk("R6 err", err, 1'b1);
      chk("R6 sts", gpe_sts, 8'h00);
      @(negedge clk);
      chk("R6 err pulse", hp_err, 1'b0);
      evt(9'd256, 1'b1, err);
      chk("R6 err 256", err, 1'b1);
      scan_all("R6 bitmap kept");

      // R10 writes ignored
      @(negedge clk);
      io_addr = 16'hAF00; io_wr = 1'b1; io_wdata = 8'hA5;
      @(negedge clk);
      io_addr = 16'hAF1F; io_wdata = 8'h00;
      @(negedge clk);
      io_wr = 1'b0;
      scan_all("R10 write ignored");

      // R11 reads outside the window
      rd(16'hAEFF, d, en);
      chk("R11 below en", en, 1'b0);
      chk("R11 below data", d, 8'h00);
      rd(16'hAF20, d, en);
      chk("R11 above en", en, 1'b0);
      chk("R11 above data", d, 8'h00);
      rd(16'hAF1F, d, en);
      chk("R2 last byte", d, ref_map[255:248]);

      // R7 interrupt combining
      evt(9'd40, 1'b0, err);
      gpe_en = 8'h00; #1;
      chk("R7 disabled", sci, 1'b0);
      gpe_en = 8'hFB; #1;
      chk("R7 other en bits", sci, 1'b0);
      gpe_en = 8'h04; #1;
      chk("R7 cpu src", sci, 1'b1);
      pm_irq_in = 1'b1; gpe_en = 8'h00; #1;
      chk("R7 pm src", sci, 1'b1);
      pm_irq_in = 1'b0; gpe_en = 8'h04;

      // R9 set and clear in the same cycle
      @(negedge clk);
      hp_valid = 1'b1; hp_id = 9'd41; hp_remove = 1'b0;
      sts_clr_wr = 1'b1; sts_clr_data = 8'h04;
      @(negedge clk);
      hp_valid = 1'b0; sts_clr_wr = 1'b0;
      ref_map[41] = 1'b1;
      chk("R9 set wins", gpe_sts[2], 1'b1);
      chk("R9 sci held", sci, 1'b1);

      // R12 device event, R8 partial clear
      @(negedge clk);
      dev_evt = 1'b1;
      @(negedge clk);
      dev_evt = 1'b0;
      chk("R12 dev bit", gpe_sts, 8'h06);
      clr(8'h04);
      ref_sts = 8'h02;
      chk("R8 partial", gpe_sts, 8'h02);
      gpe_en = 8'h02; #1;
      chk("R7 dev src", sci, 1'b1);
      clr(8'h02);
      chk("R8 all clear", gpe_sts, 8'h00);
      chk("R8 sci drop", sci, 1'b0);
      scan_all("R3 final scan");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule